// File: doc/BRIEF.md
# Audio Soft-Unmute / Hard-Mute Controller

This block gates the audio words leaving a sample rate converter on their way to the serial data output. It scales each output sample by a gain taken from a ramp counter. The gain is zero after reset and whenever the converter reports a problem. It climbs back to unity one step per output sample once all problems are gone. Muting is asymmetric. Any asserted fault flag silences the output on the next clock edge. Recovery is a gradual fade-in that lasts 2^RAMP_BITS output sample periods (4096 with the default setting).

Everything runs in the output clock domain. The fault flags are ORed and sampled on the same edge as the sample strobe. A mute status output tells downstream logic whether the gain is still below unity.

Top module: `audio_mute_ramp`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle shows `smp_out` = 0 and `muted` = 1, and the ramp position is cleared to gain 0.
- R2: If any bit of `bad_flags` is high at a rising edge, `smp_out` is 0 and the gain is 0 from the next cycle on. This holds even when `smp_stb` is high on that same edge.
- R3: The gain stays at 0 for as long as at least one flag is high. Clearing one flag while another is still set leaves the output at zero.
- R4: On an edge with `smp_stb` high, `rst` low and no flag set, `smp_out` becomes (`smp_in` × g) / 2^RAMP_BITS, where g is the gain before that edge. After that edge the gain becomes min(g+1, 2^RAMP_BITS).
- R5: The first strobe after a mute yields exactly 0. Once 2^RAMP_BITS strobes have passed with no flag set, the gain is unity and `smp_out` equals `smp_in` at each strobe.
- R6: `muted` is 1 exactly when the current gain is below 2^RAMP_BITS.
- R7: On edges with `smp_stb` low and no reset or flag, `smp_out` holds its previous value.
- R8: The division in R4 truncates toward zero for negative products, so scaled values are symmetric about zero. For example, -1 at any gain below unity gives 0.
- R9: A flag that rises partway through a ramp sends the gain back to 0. The next fade-in starts again from silence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-domain clock |
| rst | input | 1 | Synchronous active-high reset, forces mute |
| smp_stb | input | 1 | One-cycle strobe per output sample |
| smp_in | input | SAMPLE_W | Signed sample from the converter |
| bad_flags | input | FLAG_N | Fault conditions, any high means invalid |
| smp_out | output | SAMPLE_W | Gain-scaled signed sample |
| muted | output | 1 | High while gain is below unity |

## Verification
The bench builds the block with RAMP_BITS = 6 and FLAG_N = 3, so a full fade-in takes only 64 strobes. This lets it reach unity several times and interrupt ramps at varied depths. Three flags are enough to clear one flag while another is still set. The sample width stays at 24 bits, so the full negative and positive extremes are driven through the product and the rounding path.

// File: rtl/audio_mute_ramp.sv
module audio_mute_ramp #(
  parameter int SAMPLE_W  = 24,
  parameter int RAMP_BITS = 12,
  parameter int FLAG_N    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_stb,
  input  logic [SAMPLE_W-1:0] smp_in,
  input  logic [FLAG_N-1:0]   bad_flags,
  output logic [SAMPLE_W-1:0] smp_out,
  output logic                muted
);
  localparam int PW = SAMPLE_W + RAMP_BITS + 2;
  localparam int QW = SAMPLE_W + 2;

  logic [RAMP_BITS:0]   gain;
  logic [SAMPLE_W-1:0]  out_q;

  wire bad      = |bad_flags;
  wire at_unity = gain[RAMP_BITS];

  wire signed [PW-1:0] in_ext   = {{(PW-SAMPLE_W){smp_in[SAMPLE_W-1]}}, smp_in};
  wire signed [PW-1:0] gain_ext = {{(PW-RAMP_BITS-1){1'b0}}, gain};
  wire signed [PW-1:0] prod     = in_ext * gain_ext;

  wire signed [QW-1:0] floor_q  = prod[PW-1:RAMP_BITS];
  wire                 round_up = prod[PW-1] & (|prod[RAMP_BITS-1:0]);
  wire signed [QW-1:0] scaled   = floor_q + {{(QW-1){1'b0}}, round_up};

  always_ff @(posedge clk) begin
    if (rst || bad) begin
      gain  <= '0;
      out_q <= '0;
    end else if (smp_stb) begin
      out_q <= scaled[SAMPLE_W-1:0];
      if (!at_unity) gain <= gain + 1'b1;
    end
  end

  assign smp_out = out_q;
  assign muted   = !at_unity;

  assert_reset_mute_R1: assert property (@(posedge clk)
    rst |=> (smp_out == '0 && muted));

  assert_hard_mute_R2: assert property (@(posedge clk) disable iff (rst)
    (|bad_flags) |=> (smp_out == '0 && muted));

  assert_unity_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && !(|bad_flags) && !muted) |=> (smp_out == $past(smp_in)));

  assert_unmute_on_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(muted) |-> ($past(smp_stb) && !$past(|bad_flags)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!smp_stb && !(|bad_flags)) |=> $stable(smp_out));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (scaled[QW-1:SAMPLE_W-1] == '0) || (scaled[QW-1:SAMPLE_W-1] == '1));
endmodule

// File: tb/test_audio_mute_ramp.sv
module test_audio_mute_ramp;
  localparam int SW = 24;
  localparam int RB = 6;
  localparam int FN = 3;
  localparam longint FULL = 64'sd1 << RB;

  logic clk = 0;
  logic rst = 1;
  logic stb = 0;
  logic [SW-1:0] din = '0;
  logic [FN-1:0] flags = '0;
  logic [SW-1:0] dout;
  logic muted;

  int checks = 0;
  int fails = 0;
  longint m_gain = 0;
  longint m_out = 0;
  string phase = "R1";
  int seed = 12345;

  always #5 clk = ~clk;

  audio_mute_ramp #(.SAMPLE_W(SW), .RAMP_BITS(RB), .FLAG_N(FN)) i_audio_mute_ramp (
    .clk(clk), .rst(rst), .smp_stb(stb), .smp_in(din), .bad_flags(flags),
    .smp_out(dout), .muted(muted)
  );

  function automatic longint sx(input logic [SW-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic step(input logic r, input logic s, input longint v, input logic [FN-1:0] f);
    @(negedge clk);
    rst = r; stb = s; din = v[SW-1:0]; flags = f;
    if (r || f != 0) begin
      m_gain = 0; m_out = 0;
    end else if (s) begin
      m_out = (sx(din) * m_gain) / FULL;
      if (m_gain < FULL) m_gain = m_gain + 1;
    end
    @(posedge clk); #1;
    checks++;
    if (sx(dout) != m_out) begin
      fails++;
      $display("FAIL %s smp_out actual=%0d expected=%0d", phase, sx(dout), m_out);
    end
    checks++;
    if (muted != (m_gain < FULL)) begin
      fails++;
      $display("FAIL %s/R6 muted actual=%0b expected=%0b", phase, muted, m_gain < FULL);
    end
  endtask

  function automatic longint rnd();
    seed = seed * 1103515245 + 12345;
    return longint'($signed(seed[23:0] ^ seed[31:8]));
  endfunction

  task automatic ramp(input int n, input longint v, input bit vary, input logic [FN-1:0] f);
    for (int i = 0; i < n; i++) begin
      step(0, 1, vary ? rnd() : v, f);
      step(0, 0, rnd(), f);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    phase = "R1";
    for (int i = 0; i < 4; i++) step(1, i[0], 1000, '0);
    phase = "R4/R5/R7 constant ramp";
    ramp(70, 1000, 0, '0);
    phase = "R4 random ramp";
    step(1, 0, 0, '0);
    ramp(80, 0, 1, '0);
    phase = "R8 negative";
    step(0, 0, 0, 3'b001);
    ramp(10, -1, 0, '0);
    ramp(20, -12345, 0, '0);
    ramp(40, -(64'sd1 << 23), 0, '0);
    phase = "R4 max positive";
    ramp(5, (64'sd1 << 23) - 1, 0, '0);
    phase = "R2 strobe with flag";
    step(0, 1, 5000, 3'b100);
    phase = "R9 interrupt";
    ramp(20, 7777, 0, '0);
    step(0, 0, 0, 3'b010);
    ramp(30, 7777, 0, '0);
    step(0, 1, 7777, 3'b001);
    ramp(70, 0, 1, '0);
    phase = "R3 overlapping flags";
    ramp(3, 4000, 0, 3'b101);
    ramp(5, 4000, 0, 3'b100);
    ramp(70, 4000, 0, '0);
    phase = "R1 reset mid-stream";
    step(1, 1, 4000, '0);
    ramp(10, -3000, 0, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule